// File: doc/BRIEF.md
# Constant-Sequence Modular Exponentiation Engine

The engine raises a base to an exponent modulo an odd modulus n and returns `base^exp mod n`. It is meant for secret exponents: whatever the exponent value, the sequence of arithmetic operations and the total run time are the same. The exponent is walked from its top bit down to bit 0. Each bit gets one modular square, and then one modular multiply by the base. When the bit is zero, that multiply is still performed, but its product goes to a scratch register and the running accumulator is left as it was.

All products come from one radix-2, bit-serial Montgomery multiplier. For an operand width W, the caller supplies R2 = 2^(2W) mod n. Before the scan, the engine moves the accumulator (value 1) and the base into the Montgomery domain. After the scan, a final product with 1 moves the result back out. A job is launched with a one-cycle `start`. `busy` is high while it runs, and `done` pulses once when the result is ready. Operand width and exponent width are parameters. The default of 32 bits keeps simulation short, and the structure scales to 1024 bits and beyond.

Top module: `modexp_regular`

## Requirements
- R1: For odd n with 3 <= n < 2^W, base < n and r2 = 2^(2W) mod n, `result_o` equals base^exp mod n when `done_o` is high. An exponent of 0 gives 1.
- R2: The exponent is consumed from bit EW-1 down to bit 0. Each bit takes one square followed by one multiply, and a job takes exactly 2*EW+3 Montgomery products: two entry conversions, 2*EW scan products and one exit conversion.
- R3: The multiply issued for a zero exponent bit writes only the scratch register. The accumulator holds its value across that write-back.
- R4: `done_o` rises exactly (2*EW+3)*(W+3) clock cycles after the edge that accepts `start_i`, whatever the exponent (2345 cycles at the defaults).
- R5: `done_o` is high for exactly one cycle. `result_o` keeps its value from then until a new job writes it.
- R6: `busy_o` rises at the edge that accepts `start_i`. It falls at the same edge where `done_o` rises.
- R7: `start_i` has no effect while `busy_o` is high. The operands captured at acceptance, the result and the latency are those of the running job.
- R8: `start_i` held high in the cycle where `done_o` is high is accepted. The new job then runs with the full latency of R4.
- R9: Every Montgomery product, the final result included, is less than n.
- R10: With `rst_n` low at a clock edge, `busy_o`, `done_o` and `result_o` are all 0 after that edge, including when reset arrives in the middle of a job.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Launch request, accepted only when not busy |
| base_i | input | W | Base, must be below n |
| exp_i | input | EW | Exponent |
| mod_i | input | W | Odd modulus n, at least 3 |
| r2_i | input | W | Precomputed 2^(2W) mod n |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | W | base^exp mod n |

## Verification
Two things can land in the same clock cycle: one job finishing with its `done` pulse, and the next job being accepted because `start_i` is held high during that pulse. The bench provokes this by raising `start_i` with new operands as soon as it sees `done_o`. It then checks three things: `busy_o` is high on the next sample, the second job takes exactly the R4 cycle count from that edge, and the second result matches the reference. A related collision, `start_i` arriving while a job is in flight, is provoked with different operands partway through a run. It is judged by an unchanged result and an unchanged latency.

// File: rtl/modexp_pkg.sv
// Shared types for the constant-sequence modular exponentiation engine.
package modexp_pkg;

    // Phase of the bit-serial Montgomery multiplier
    typedef enum logic [1:0] {
        MM_IDLE = 2'd0,
        MM_LOOP = 2'd1,
        MM_SUB  = 2'd2
    } mm_phase_t;

    // Phase of the operation scheduler
    typedef enum logic [1:0] {
        CT_IDLE  = 2'd0,
        CT_ISSUE = 2'd1,
        CT_WAIT  = 2'd2
    } ctl_state_t;

    // Operand sources for a Montgomery product
    typedef enum logic [2:0] {
        SRC_ONE  = 3'd0,
        SRC_R2   = 3'd1,
        SRC_BASE = 3'd2,
        SRC_ACC  = 3'd3
    } src_t;

    // Write-back destinations for a Montgomery product
    typedef enum logic [1:0] {
        DST_ACC     = 2'd0,
        DST_BASE    = 2'd1,
        DST_SCRATCH = 2'd2,
        DST_RESULT  = 2'd3
    } dest_t;

endpackage

// File: rtl/mont_mul_serial.sv
// Radix-2 bit-serial Montgomery multiplier: p = a*b*2^-W mod n.
// Assumes n odd, b < n, and go only while idle. Takes W iteration
// cycles plus one conditional-subtraction cycle; rdy_o pulses with p_o.
module mont_mul_serial
    import modexp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] n_i,
    output logic         rdy_o,
    output logic [W-1:0] p_o
);
    localparam int TW = W + 2;
    localparam int CW = $clog2(W + 1);

    mm_phase_t      phase_q;
    logic [TW-1:0]  t_q;
    logic [W-1:0]   a_sh_q;
    logic [W-1:0]   b_q;
    logic [W-1:0]   n_q;
    logic [CW-1:0]  cnt_q;
    logic [TW-1:0]  add1;
    logic [TW-1:0]  add2;
    logic [TW-1:0]  t_next;
    logic [TW-1:0]  t_diff;
    logic           t_ge_n;

    // One Montgomery iteration: add a-bit times b, make even with n, halve
    always_comb begin
        add1   = t_q + (a_sh_q[0] ? {2'b00, b_q} : '0);
        add2   = add1[0] ? add1 + {2'b00, n_q} : add1;
        t_next = add2 >> 1;
        t_diff = t_q - {2'b00, n_q};
        t_ge_n = (t_q >= {2'b00, n_q});
    end

    // Sequencing of load, W iterations and final reduction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= MM_IDLE;
            t_q     <= '0;
            a_sh_q  <= '0;
            b_q     <= '0;
            n_q     <= '0;
            cnt_q   <= '0;
            rdy_o   <= 1'b0;
            p_o     <= '0;
        end else begin
            rdy_o <= 1'b0;
            case (phase_q)
                MM_IDLE: begin
                    if (go_i) begin
                        a_sh_q  <= a_i;
                        b_q     <= b_i;
                        n_q     <= n_i;
                        t_q     <= '0;
                        cnt_q   <= '0;
                        phase_q <= MM_LOOP;
                    end
                end
                MM_LOOP: begin
                    t_q    <= t_next;
                    a_sh_q <= a_sh_q >> 1;
                    cnt_q  <= cnt_q + 1'b1;
                    if (cnt_q == CW'(W - 1)) begin
                        phase_q <= MM_SUB;
                    end
                end
                MM_SUB: begin
                    p_o     <= t_ge_n ? t_diff[W-1:0] : t_q[W-1:0];
                    rdy_o   <= 1'b1;
                    phase_q <= MM_IDLE;
                end
                default: phase_q <= MM_IDLE;
            endcase
        end
    end

    AST_PRODUCT_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> (p_o < n_q)); // R9
    AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (phase_q == MM_IDLE)); // R7
    AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |=> !rdy_o); // R4

endmodule

// File: rtl/modexp_sched.sv
// Operation scheduler. Walks the exponent MSB first and issues, per bit,
// one square and one multiply; a zero bit steers the multiply into the
// scratch register. Step 0 and 1 enter the Montgomery domain, the last
// step leaves it. Assumes the multiplier answers every go with one rdy.
module modexp_sched
    import modexp_pkg::*;
#(
    parameter int EW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [EW-1:0] exp_i,
    input  logic          mm_rdy_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          load_o,
    output logic          go_o,
    output src_t          src_a_o,
    output src_t          src_b_o,
    output dest_t         dest_o,
    output logic          wb_o
);
    localparam int NOPS = 2 * EW + 3;
    localparam int SW   = $clog2(NOPS);
    localparam int LAST = NOPS - 1;

    ctl_state_t     state_q;
    logic [SW-1:0]  step_q;
    logic [EW-1:0]  exp_q;
    logic           is_last;
    logic           is_mul;

    // Step classification
    always_comb begin
        is_last = (step_q == SW'(LAST));
        is_mul  = step_q[0] && (step_q != SW'(1));
    end

    // Operand and destination selection for the current step
    always_comb begin
        src_a_o = SRC_ACC;
        src_b_o = SRC_ACC;
        dest_o  = DST_ACC;
        if (step_q == '0) begin
            src_a_o = SRC_R2;
            src_b_o = SRC_ONE;
            dest_o  = DST_ACC;
        end else if (step_q == SW'(1)) begin
            src_a_o = SRC_BASE;
            src_b_o = SRC_R2;
            dest_o  = DST_BASE;
        end else if (is_last) begin
            src_a_o = SRC_ACC;
            src_b_o = SRC_ONE;
            dest_o  = DST_RESULT;
        end else if (is_mul) begin
            src_a_o = SRC_ACC;
            src_b_o = SRC_BASE;
            dest_o  = exp_q[EW-1] ? DST_ACC : DST_SCRATCH;
        end
    end

    // Handshake outputs
    always_comb begin
        busy_o = (state_q != CT_IDLE);
        load_o = (state_q == CT_IDLE) && start_i;
        go_o   = (state_q == CT_ISSUE);
        wb_o   = (state_q == CT_WAIT) && mm_rdy_i;
    end

    // Step sequencing, exponent shifting and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CT_IDLE;
            step_q  <= '0;
            exp_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                CT_IDLE: begin
                    if (start_i) begin
                        step_q  <= '0;
                        exp_q   <= exp_i;
                        state_q <= CT_ISSUE;
                    end
                end
                CT_ISSUE: state_q <= CT_WAIT;
                CT_WAIT: begin
                    if (mm_rdy_i) begin
                        if (is_mul) begin
                            exp_q <= exp_q << 1;
                        end
                        if (is_last) begin
                            state_q <= CT_IDLE;
                            done_o  <= 1'b1;
                        end else begin
                            step_q  <= step_q + 1'b1;
                            state_q <= CT_ISSUE;
                        end
                    end
                end
                default: state_q <= CT_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5
    AST_BUSY_FALLS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CT_WAIT && start_i && !mm_rdy_i) |=> (state_q == CT_WAIT && $stable(step_q))); // R7
    AST_SQUARE_THEN_MUL: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_o && !is_mul && step_q > SW'(1) && !is_last) |=> (state_q == CT_ISSUE && is_mul)); // R2

endmodule

// File: rtl/modexp_regfile.sv
// Operand storage: captures modulus, R2 constant and base at launch, holds
// the accumulator, scratch and result, feeds the multiplier through two
// source muxes and writes products back to the selected destination.
module modexp_regfile
    import modexp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] mod_i,
    input  logic [W-1:0] r2_i,
    input  src_t         src_a_i,
    input  src_t         src_b_i,
    input  dest_t        dest_i,
    input  logic         wb_i,
    input  logic [W-1:0] prod_i,
    output logic [W-1:0] opa_o,
    output logic [W-1:0] opb_o,
    output logic [W-1:0] mod_o,
    output logic [W-1:0] result_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] r2_q;
    logic [W-1:0] base_q;
    logic [W-1:0] acc_q;
    logic [W-1:0] scratch_q;

    // Source selection for one operand
    function automatic logic [W-1:0] pick(input src_t s, input logic [W-1:0] r2,
                                          input logic [W-1:0] bs, input logic [W-1:0] ac);
        case (s)
            SRC_R2:   pick = r2;
            SRC_BASE: pick = bs;
            SRC_ACC:  pick = ac;
            default:  pick = ONE;
        endcase
    endfunction

    // Operand muxes toward the multiplier
    always_comb begin
        opa_o = pick(src_a_i, r2_q, base_q, acc_q);
        opb_o = pick(src_b_i, r2_q, base_q, acc_q);
    end

    // Launch capture and product write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r2_q      <= '0;
            base_q    <= '0;
            mod_o     <= '0;
            acc_q     <= '0;
            scratch_q <= '0;
            result_o  <= '0;
        end else if (load_i) begin
            r2_q   <= r2_i;
            base_q <= base_i;
            mod_o  <= mod_i;
        end else if (wb_i) begin
            case (dest_i)
                DST_ACC:     acc_q     <= prod_i;
                DST_BASE:    base_q    <= prod_i;
                DST_SCRATCH: scratch_q <= prod_i;
                default:     result_o  <= prod_i;
            endcase
        end
    end

    AST_DUMMY_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_i && dest_i == DST_SCRATCH) |=> $stable(acc_q)); // R3
    AST_DUMMY_TO_SCRATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_i && dest_i == DST_SCRATCH) |=> (scratch_q == $past(prod_i))); // R3
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wb_i || dest_i != DST_RESULT) |=> $stable(result_o)); // R5

endmodule

// File: rtl/modexp_regular.sv
// Top of the constant-sequence modular exponentiation engine. Joins the
// scheduler, operand storage and the bit-serial Montgomery multiplier.
// Assumes odd modulus >= 3, base < modulus and r2 = 2^(2W) mod modulus.
module modexp_regular
    import modexp_pkg::*;
#(
    parameter int W  = 32,
    parameter int EW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [W-1:0]  base_i,
    input  logic [EW-1:0] exp_i,
    input  logic [W-1:0]  mod_i,
    input  logic [W-1:0]  r2_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [W-1:0]  result_o
);
    logic         load;
    logic         go;
    logic         wb;
    logic         mm_rdy;
    src_t         src_a;
    src_t         src_b;
    dest_t        dest;
    logic [W-1:0] opa;
    logic [W-1:0] opb;
    logic [W-1:0] mod_q;
    logic [W-1:0] prod;

    modexp_sched #(.EW(EW)) sched_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .exp_i    (exp_i),
        .mm_rdy_i (mm_rdy),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .load_o   (load),
        .go_o     (go),
        .src_a_o  (src_a),
        .src_b_o  (src_b),
        .dest_o   (dest),
        .wb_o     (wb)
    );

    modexp_regfile #(.W(W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .base_i   (base_i),
        .mod_i    (mod_i),
        .r2_i     (r2_i),
        .src_a_i  (src_a),
        .src_b_i  (src_b),
        .dest_i   (dest),
        .wb_i     (wb),
        .prod_i   (prod),
        .opa_o    (opa),
        .opb_o    (opb),
        .mod_o    (mod_q),
        .result_o (result_o)
    );

    mont_mul_serial #(.W(W)) mm_i (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (go),
        .a_i   (opa),
        .b_i   (opb),
        .n_i   (mod_q),
        .rdy_o (mm_rdy),
        .p_o   (prod)
    );

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o); // R6
    AST_RESULT_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (result_o < mod_q)); // R9

endmodule

// File: tb/modexp_regular_tb.sv
module modexp_regular_tb_top;
    localparam int W  = 32;
    localparam int EW = 32;
    localparam int LAT = (2 * EW + 3) * (W + 3);
    localparam int NVEC = 8;

    // Stimulus rows: {modulus, base, exponent}
    localparam logic [95:0] VEC [NVEC] = '{
        {32'hFFFF_FFFB, 32'h0000_0002, 32'h0000_0019},
        {32'hC000_0001, 32'h1234_5678, 32'h0000_0000},
        {32'hF123_4567, 32'hABCD_EF01, 32'hFFFF_FFFF},
        {32'h0000_0007, 32'h0000_0003, 32'h8000_0000},
        {32'h0000_0003, 32'h0000_0002, 32'h0000_0001},
        {32'h9E37_79B9, 32'h0000_0000, 32'h0000_0005},
        {32'h8000_0001, 32'h8000_0000, 32'h1234_5678},
        {32'hDEAD_BEEF, 32'hDEAD_BEEE, 32'h0000_0002}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [W-1:0]  base_i = '0;
    logic [EW-1:0] exp_i = '0;
    logic [W-1:0]  mod_i = 32'h5;
    logic [W-1:0]  r2_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [W-1:0]  result_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    modexp_regular #(.W(W), .EW(EW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .base_i   (base_i),
        .exp_i    (exp_i),
        .mod_i    (mod_i),
        .r2_i     (r2_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .result_o (result_o)
    );

    function automatic logic [W-1:0] ref_pow(input logic [W-1:0] n, input logic [W-1:0] b,
                                             input logic [EW-1:0] e);
        logic [63:0] r = 64'd1;
        for (int i = EW - 1; i >= 0; i--) begin
            r = (r * r) % {32'd0, n};
            if (e[i]) r = (r * {32'd0, b}) % {32'd0, n};
        end
        return r[W-1:0];
    endfunction

    function automatic logic [W-1:0] ref_r2(input logic [W-1:0] n);
        logic [63:0] r = 64'd1;
        for (int i = 0; i < 2 * W; i++) r = (r << 1) % {32'd0, n};
        return r[W-1:0];
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // At a negedge: present operands, pulse start over one edge
    task automatic launch(input logic [W-1:0] n, input logic [W-1:0] b, input logic [EW-1:0] e);
        mod_i = n; base_i = b; exp_i = e; r2_i = ref_r2(n);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Count cycles from the accepting edge until done; optional mid-run poke
    task automatic wait_done(output int cyc, input int poke_at);
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (cyc == poke_at) begin
                start_i = 1'b1; base_i = 32'h1; exp_i = 32'h3; mod_i = 32'h11; r2_i = 32'h1;
            end else if (cyc == poke_at + 1) begin
                start_i = 1'b0;
            end
            if (done_o) break;
            if (cyc > LAT + 2000) begin
                check(1'b0, "watchdog", 64'(cyc), 64'(LAT));
                break;
            end
        end
    endtask

    task automatic run_one(input logic [W-1:0] n, input logic [W-1:0] b, input logic [EW-1:0] e,
                           input string tag);
        int cyc;
        logic [W-1:0] expv;
        expv = ref_pow(n, b, e);
        launch(n, b, e);
        check(busy_o == 1'b1, "R6 busy after start", 64'(busy_o), 64'd1);
        wait_done(cyc, -10);
        check(result_o == expv, tag, 64'(result_o), 64'(expv));
        check(cyc == LAT, "R4/R2 fixed latency", 64'(cyc), 64'(LAT));
        check(busy_o == 1'b0, "R6 busy low at done", 64'(busy_o), 64'd0);
        check(result_o < n, "R9 result below modulus", 64'(result_o), 64'(n));
    endtask

    initial begin
        int cyc;
        logic [W-1:0] hold;
        logic [W-1:0] ea;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(busy_o == 1'b0 && done_o == 1'b0 && result_o == '0, "R10 reset state",
              {31'd0, busy_o, done_o, result_o}, 64'd0);

        // R1/R2/R4: vector table
        for (int k = 0; k < NVEC; k++) begin
            run_one(VEC[k][95:64], VEC[k][63:32], VEC[k][31:0], "R1 table result");
        end

        // R5: done pulse width and result hold
        hold = result_o;
        @(negedge clk);
        check(done_o == 1'b0, "R5 done one cycle", 64'(done_o), 64'd0);
        repeat (10) @(negedge clk);
        check(result_o == hold, "R5 result held", 64'(result_o), 64'(hold));

        // R1/R3: random odd moduli, exponents incl. all zeros and all ones
        for (int k = 0; k < 6; k++) begin
            logic [W-1:0] n;
            logic [W-1:0] b;
            logic [EW-1:0] e;
            n = $urandom() | 32'h1;
            if (n < 3) n = 32'h5;
            b = $urandom() % n;
            e = (k == 0) ? '0 : (k == 1) ? '1 : $urandom();
            run_one(n, b, e, "R1/R3 random result");
        end

        // R7: start while busy is ignored
        ea = ref_pow(32'hFFF0_0001, 32'h0BAD_F00D, 32'hA5A5_0F0F);
        launch(32'hFFF0_0001, 32'h0BAD_F00D, 32'hA5A5_0F0F);
        wait_done(cyc, 500);
        check(result_o == ea, "R7 start ignored result", 64'(result_o), 64'(ea));
        check(cyc == LAT, "R7 start ignored latency", 64'(cyc), 64'(LAT));

        // R8: start held in the done cycle launches back-to-back
        ea = ref_pow(32'h7FFF_FFFF, 32'h1357_9BDF, 32'h0F0F_0001);
        launch(32'h7FFF_FFFF, 32'h1357_9BDF, 32'h0F0F_0001);
        check(busy_o == 1'b1, "R8 busy after back-to-back start", 64'(busy_o), 64'd1);
        wait_done(cyc, -10);
        check(result_o == ea, "R8 back-to-back result", 64'(result_o), 64'(ea));
        check(cyc == LAT, "R8 back-to-back latency", 64'(cyc), 64'(LAT));

        // R10: reset in the middle of a job
        launch(32'h0001_0001, 32'h3, 32'hFFFF);
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0 && result_o == '0, "R10 mid-run reset",
              {31'd0, busy_o, done_o, result_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_one(32'h0001_0001, 32'h3, 32'h0000_FFFF, "R1 after reset result");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Global watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule